// File: doc/BRIEF.md
# Pad Function Multiplexer with Sleep Flag Set

This block owns a bank of sixteen pad configuration registers and steers one of five candidate sources onto each of sixteen pads. A register picks the function for its pad (A through E) and carries two sets of pad control flags, one used in normal operation and one used while the chip is asleep. One of the five functions on every pad is the general-purpose I/O port; the other four belong to peripherals that sit outside this block and present an output value and an output enable per pad and per function slot.

Software reaches the registers through a simple word-wide write/read port. The registers are not stored in pad order: register index X sits at byte offset 4*(X+1) and serves a pad chosen by a fixed scrambled table. Which function code means "general-purpose I/O" also depends on the register index, so drivers must use the right code per register.

Top module: `pad_func_mux`

## Requirements
- R1: After reset every register reads zero, so every pad selects function A with all flags clear and pad_oe low on all pads.
- R2: Register index X (0..15) is at byte offset 4*(X+1) (0x04..0x40). Only bits 0-7 and 12 are stored (write mask 0x000010FF); other bits read zero. Offsets that are unaligned or outside 0x04..0x40 read zero and ignore writes.
- R3: Register index 0..15 serves pad (GPIO number) 12, 13, 14, 15, 3, 1, 6, 7, 8, 9, 10, 11, 0, 2, 4, 5 respectively.
- R4: The function code is taken from bits {12,5,4}: A = none set, B = bit 4, C = bit 5, D = bits 4 and 5, E = bit 12. A peripheral function k (A=0..E=4) on pad g takes fn_out/fn_oe bit g*5+k.
- R5: The general-purpose I/O function is code D for register indices 0..11 and code A for indices 12..15; then pad_out[g] = gpio_out[g] and pad_oe[g] = active OE flag AND gpio_dir[g]. On those registers the other code selects the peripheral slot.
- R6: For a peripheral function, pad_oe is the active OE flag AND the selected slot's fn_oe bit; pad_out is that slot's fn_out bit.
- R7: With sleep_mode low the active flags are output enable bit 0, pull-down bit 6 and pull-up bit 7, shown on pad_oe gating, pad_pd and pad_pu.
- R8: With sleep_mode high the active flags are output enable bit 1, pull-down bit 2 and pull-up bit 3; bits 0, 6 and 7 have no effect.
- R9: A function field of bit 12 together with bit 4 or bit 5 selects nothing: pad_out and pad_oe are low for that pad whatever the sources do; pulls still follow the flags.
- R10: With cfg_wr low, no register changes whatever cfg_addr and cfg_wdata carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_addr | input | 8 | Byte offset of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| sleep_mode | input | 1 | Selects the sleep flag set when high |
| gpio_out | input | 16 | General-purpose port output value per pad |
| gpio_dir | input | 16 | General-purpose port direction per pad, 1 = drive |
| fn_out | input | 80 | Peripheral output values, bit g*5+k for pad g function k |
| fn_oe | input | 80 | Peripheral output enables, same indexing as fn_out |
| pad_out | output | 16 | Value presented to each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_pu | output | 16 | Pull-up request for each pad |
| pad_pd | output | 16 | Pull-down request for each pad |

## Verification
The two functions that meet in one cycle are a register write that rewrites a pad's sleep and normal flags and a change of sleep_mode, which decides which of those flags reach the pad. The bench provokes the overlap with a directed case and then with a long stretch of random writes, random offsets and a randomly toggling sleep_mode, and a behavioural model that updates its register copy at the write edge and picks the flag set from the sleep level judges all pad outputs and the read data on every clock.

// File: rtl/pfmux_pkg.sv
package pfmux_pkg;

  localparam int WORD_W     = 32;
  localparam int BANK_SIZE  = 16;
  localparam int GPIO_SPLIT = 12;
  localparam int FN_SLOTS   = 5;

  // bit positions inside a configuration word
  localparam int B_OE     = 0;
  localparam int B_OE_SLP = 1;
  localparam int B_PD_SLP = 2;
  localparam int B_PU_SLP = 3;
  localparam int B_FS0    = 4;
  localparam int B_FS1    = 5;
  localparam int B_PD     = 6;
  localparam int B_PU     = 7;
  localparam int B_FS2    = 12;

  localparam logic [WORD_W-1:0] CFG_WMASK = 32'h0000_10FF;

  typedef enum logic [2:0] {
    FN_A    = 3'd0,
    FN_B    = 3'd1,
    FN_C    = 3'd2,
    FN_D    = 3'd3,
    FN_E    = 3'd4,
    FN_NONE = 3'd7
  } fn_sel_e;

  typedef struct packed {
    logic fs2;
    logic pu;
    logic pd;
    logic fs1;
    logic fs0;
    logic pu_slp;
    logic pd_slp;
    logic oe_slp;
    logic oe;
  } pad_cfg_t;

  function automatic int gpio_of_index(input int x);
    case (x)
      0: return 12;  1: return 13;  2: return 14;  3: return 15;
      4: return 3;   5: return 1;   6: return 6;   7: return 7;
      8: return 8;   9: return 9;  10: return 10; 11: return 11;
      12: return 0; 13: return 2;  14: return 4;  default: return 5;
    endcase
  endfunction

  function automatic int index_of_gpio(input int g);
    int r;
    r = 0;
    for (int x = 0; x < BANK_SIZE; x++)
      if (gpio_of_index(x) == g) r = x;
    return r;
  endfunction

  function automatic fn_sel_e decode_fn(input pad_cfg_t c);
    case ({c.fs2, c.fs1, c.fs0})
      3'b000:  return FN_A;
      3'b001:  return FN_B;
      3'b010:  return FN_C;
      3'b011:  return FN_D;
      3'b100:  return FN_E;
      default: return FN_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input pad_cfg_t c);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[B_OE]     = c.oe;
    w[B_OE_SLP] = c.oe_slp;
    w[B_PD_SLP] = c.pd_slp;
    w[B_PU_SLP] = c.pu_slp;
    w[B_FS0]    = c.fs0;
    w[B_FS1]    = c.fs1;
    w[B_PD]     = c.pd;
    w[B_PU]     = c.pu;
    w[B_FS2]    = c.fs2;
    return w;
  endfunction

endpackage

// File: rtl/pfmux_cfg_bank.sv
module pfmux_cfg_bank
  import pfmux_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output pad_cfg_t [NUM_REGS-1:0]      cfg_q
);

  localparam int WA    = ADDR_W - 2;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [WA-1:0]    word;
  logic             hit;
  logic [IDX_W-1:0] idx;
  pad_cfg_t         cfg_d;

  assign word = addr[ADDR_W-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (word >= WA'(1)) && (word <= WA'(NUM_REGS));
  assign idx  = IDX_W'(word - WA'(1));

  wire unused_wdata = ^{wdata[DATA_W-1:B_FS2+1], wdata[B_FS2-1:B_PU+1]};

  // next-state value shared by all registers
  always_comb begin
    cfg_d        = '0;
    cfg_d.oe     = wdata[B_OE];
    cfg_d.oe_slp = wdata[B_OE_SLP];
    cfg_d.pd_slp = wdata[B_PD_SLP];
    cfg_d.pu_slp = wdata[B_PU_SLP];
    cfg_d.fs0    = wdata[B_FS0];
    cfg_d.fs1    = wdata[B_FS1];
    cfg_d.pd     = wdata[B_PD];
    cfg_d.pu     = wdata[B_PU];
    cfg_d.fs2    = wdata[B_FS2];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic ld;
    assign ld = wr_en & hit & (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q[i] <= '0;
      else if (ld) cfg_q[i] <= cfg_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = DATA_W'(cfg_to_word(cfg_q[idx]));
  end

  // R2: unstored bit positions never appear on the read port
  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~DATA_W'(CFG_WMASK)) == '0);

  // R2: unaligned offsets read zero
  a_r2_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rdata == '0));

  // R10: without a write strobe the bank keeps its contents
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/pfmux_pad_lane.sv
module pfmux_pad_lane
  import pfmux_pkg::*;
#(
  parameter int REG_IDX = 0,
  parameter int SLOTS   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pad_cfg_t         cfg,
  input  logic             sleep,
  input  logic             gpio_out,
  input  logic             gpio_dir,
  input  logic [SLOTS-1:0] fn_out,
  input  logic [SLOTS-1:0] fn_oe,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_pu,
  output logic             pad_pd
);

  localparam fn_sel_e GPIO_FN = (REG_IDX < GPIO_SPLIT) ? FN_D : FN_A;

  fn_sel_e    sel;
  logic [2:0] sel_idx;
  logic       oe_flag;

  assign sel     = decode_fn(cfg);
  assign sel_idx = sel;

  // flag set chosen by the sleep input
  always_comb begin
    if (sleep) begin
      oe_flag = cfg.oe_slp;
      pad_pu  = cfg.pu_slp;
      pad_pd  = cfg.pd_slp;
    end else begin
      oe_flag = cfg.oe;
      pad_pu  = cfg.pu;
      pad_pd  = cfg.pd;
    end
  end

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (sel == GPIO_FN) begin
      pad_out = gpio_out;
      pad_oe  = oe_flag & gpio_dir;
    end else if (sel != FN_NONE) begin
      pad_out = fn_out[sel_idx];
      pad_oe  = oe_flag & fn_oe[sel_idx];
    end
  end

  // R9: an illegal function field leaves the pad undriven
  a_r9_illegal_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.fs2 && (cfg.fs0 || cfg.fs1)) |-> (!pad_oe && !pad_out));

  // R6: a pad is never enabled without its active output-enable flag
  a_r6_oe_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (sleep ? cfg.oe_slp : cfg.oe));

  // R5: general-purpose function with direction low never drives
  a_r5_dir_gates_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == GPIO_FN) && !gpio_dir) |-> !pad_oe);

  // R8: in sleep the normal output-enable flag alone cannot enable the pad
  a_r8_sleep_ignores_normal_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !cfg.oe_slp) |-> !pad_oe);

endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
  import pfmux_pkg::*;
#(
  parameter int NUM_PADS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FN_NUM   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  input  logic                       sleep_mode,
  input  logic [NUM_PADS-1:0]        gpio_out,
  input  logic [NUM_PADS-1:0]        gpio_dir,
  input  logic [NUM_PADS*FN_NUM-1:0] fn_out,
  input  logic [NUM_PADS*FN_NUM-1:0] fn_oe,
  output logic [NUM_PADS-1:0]        pad_out,
  output logic [NUM_PADS-1:0]        pad_oe,
  output logic [NUM_PADS-1:0]        pad_pu,
  output logic [NUM_PADS-1:0]        pad_pd
);

  pad_cfg_t [NUM_PADS-1:0] cfg_q;

  pfmux_cfg_bank #(
    .NUM_REGS (NUM_PADS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg_q (cfg_q)
  );

  // one lane per pad, fed from the register that serves it
  for (genvar g = 0; g < NUM_PADS; g++) begin : g_lane
    localparam int RIDX = index_of_gpio(g);
    pfmux_pad_lane #(
      .REG_IDX (RIDX),
      .SLOTS   (FN_NUM)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[RIDX]),
      .sleep    (sleep_mode),
      .gpio_out (gpio_out[g]),
      .gpio_dir (gpio_dir[g]),
      .fn_out   (fn_out[g*FN_NUM +: FN_NUM]),
      .fn_oe    (fn_oe[g*FN_NUM +: FN_NUM]),
      .pad_out  (pad_out[g]),
      .pad_oe   (pad_oe[g]),
      .pad_pu   (pad_pu[g]),
      .pad_pd   (pad_pd[g])
    );
  end

endmodule

// File: tb/pad_func_mux_tb.sv
module pad_func_mux_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sleep_mode = 1'b0;
  logic [15:0] gpio_out = '0, gpio_dir = '0;
  logic [79:0] fn_out = '0, fn_oe = '0;
  logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] ref_reg [16];
  int map_tbl [16] = '{12, 13, 14, 15, 3, 1, 6, 7, 8, 9, 10, 11, 0, 2, 4, 5};

  always #4 clk = ~clk;

  pad_func_mux u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sleep_mode(sleep_mode),
    .gpio_out(gpio_out), .gpio_dir(gpio_dir), .fn_out(fn_out), .fn_oe(fn_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference
  function automatic bit offset_ok(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a >= 8'h04) && (a <= 8'h40);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (offset_ok(a)) return ref_reg[a / 4 - 1];
    return '0;
  endfunction

  function automatic logic [3:0] exp_pad(input int g);
    int x, f, gf;
    logic [31:0] r;
    logic o, e, flag, pu, pd;
    x = 0;
    for (int i = 0; i < 16; i++) if (map_tbl[i] == g) x = i;
    r = ref_reg[x];
    if (r[12] && (r[4] || r[5])) f = -1;
    else if (r[12]) f = 4;
    else f = (r[5] ? 2 : 0) + (r[4] ? 1 : 0);
    gf   = (x < 12) ? 3 : 0;
    flag = sleep_mode ? r[1] : r[0];
    pu   = sleep_mode ? r[3] : r[7];
    pd   = sleep_mode ? r[2] : r[6];
    o = 1'b0; e = 1'b0;
    if (f == gf) begin
      o = gpio_out[g]; e = flag & gpio_dir[g];
    end else if (f >= 0) begin
      o = fn_out[g*5+f]; e = flag & fn_oe[g*5+f];
    end
    return {o, e, pu, pd};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) ref_reg[i] = '0;
    end else if (cfg_wr && offset_ok(cfg_addr)) begin
      ref_reg[cfg_addr / 4 - 1] = cfg_wdata & 32'h0000_10FF;
    end
  end

  // model comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] ev;
      logic [3:0] p;
      for (int g = 0; g < 16; g++) begin
        p = exp_pad(g);
        ev[48+g] = p[3]; ev[32+g] = p[2]; ev[16+g] = p[1]; ev[g] = p[0];
      end
      check({pad_out, pad_oe, pad_pu, pad_pd} === ev, "R3 R4 R7 R8 model pads",
            {pad_out, pad_oe, pad_pu, pad_pd}, ev);
      check(cfg_rdata === exp_rd(cfg_addr), "R2 model read", 64'(cfg_rdata), 64'(exp_rd(cfg_addr)));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step();
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step();
    cfg_addr = a;
    @(negedge clk);
    check(cfg_rdata === exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 4; a <= 64; a += 4) rd_chk(8'(a), 32'h0, "R1 reset read");
    @(negedge clk);
    check(pad_oe === 16'h0, "R1 reset pad_oe", 64'(pad_oe), 64'h0);

    // R2 layout and write mask
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0000_10FF, "R2 write mask");
    wr(8'h05, 32'h0);
    rd_chk(8'h04, 32'h0000_10FF, "R2 unaligned write ignored");
    rd_chk(8'h05, 32'h0, "R2 unaligned read zero");
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk(8'h44, 32'h0, "R2 offset 0x44 unmapped");
    rd_chk(8'h00, 32'h0, "R2 offset 0x00 unmapped");
    rd_chk(8'h40, 32'h0, "R2 last register untouched");
    wr(8'h04, 32'h0);

    // R10 strobe low
    step();
    cfg_addr = 8'h08; cfg_wdata = 32'hFFFF_FFFF; cfg_wr = 1'b0;
    step();
    rd_chk(8'h08, 32'h0, "R10 no write without strobe");

    // R3 + R5: index 4 serves pad 3, code D is GPIO there
    wr(8'h14, 32'h31);
    step();
    gpio_dir = 16'hFFFF; gpio_out = 16'h0008;
    @(negedge clk);
    check(pad_oe === 16'h0008, "R3 index 4 drives pad 3", 64'(pad_oe), 64'h8);
    check(pad_out[3] === 1'b1, "R5 gpio value on pad 3", 64'(pad_out[3]), 64'h1);

    // R5: index 12 serves pad 0, code A is GPIO there
    wr(8'h34, 32'h01);
    step();
    gpio_out = 16'h0001; gpio_dir = 16'h0000;
    @(negedge clk);
    check(pad_oe[0] === 1'b0 && pad_out[0] === 1'b1, "R5 dir low blocks oe",
          64'({pad_out[0], pad_oe[0]}), 64'h2);
    step();
    gpio_dir = 16'h0001;
    @(negedge clk);
    check(pad_oe[0] === 1'b1, "R5 dir high enables", 64'(pad_oe[0]), 64'h1);
    wr(8'h34, 32'h31);
    step();
    gpio_out = 16'h0000; fn_out = 80'h8; fn_oe = 80'h8;
    @(negedge clk);
    check(pad_out[0] === 1'b1 && pad_oe[0] === 1'b1, "R5 code D peripheral on index 12",
          64'({pad_out[0], pad_oe[0]}), 64'h3);

    // R4: index 5 serves pad 1, slots 5..9
    for (int k = 0; k < 4; k++) begin
      logic [31:0] code;
      int slot;
      code = (k == 0) ? 32'h0001 : (k == 1) ? 32'h0011 : (k == 2) ? 32'h0021 : 32'h1001;
      slot = (k == 3) ? 9 : 5 + k;
      wr(8'h18, code);
      step();
      fn_out = 80'h0; fn_out[slot] = 1'b1; fn_oe = '1;
      @(negedge clk);
      check(pad_out[1] === 1'b1 && pad_oe[1] === 1'b1, "R4 function slot high",
            64'({pad_out[1], pad_oe[1]}), 64'h3);
      step();
      fn_out = '1; fn_out[slot] = 1'b0;
      @(negedge clk);
      check(pad_out[1] === 1'b0, "R4 function slot low", 64'(pad_out[1]), 64'h0);
    end

    // R6 peripheral enable gating
    wr(8'h18, 32'h0011);
    step();
    fn_out = '1; fn_oe = '1; fn_oe[6] = 1'b0;
    @(negedge clk);
    check(pad_oe[1] === 1'b0, "R6 peripheral oe low", 64'(pad_oe[1]), 64'h0);
    wr(8'h18, 32'h0010);
    step();
    fn_oe = '1;
    @(negedge clk);
    check(pad_oe[1] === 1'b0, "R6 flag clear blocks", 64'(pad_oe[1]), 64'h0);

    // R7 normal pulls: index 6 serves pad 6
    wr(8'h1C, 32'h80);
    @(negedge clk);
    check(pad_pu[6] === 1'b1 && pad_pd[6] === 1'b0, "R7 pull-up bit 7",
          64'({pad_pu[6], pad_pd[6]}), 64'h2);
    wr(8'h1C, 32'h40);
    @(negedge clk);
    check(pad_pu[6] === 1'b0 && pad_pd[6] === 1'b1, "R7 pull-down bit 6",
          64'({pad_pu[6], pad_pd[6]}), 64'h1);

    // R8 sleep flag set, flipped in the same cycle as the write lands
    step();
    gpio_dir = '1; gpio_out = '1;
    cfg_addr = 8'h1C; cfg_wdata = 32'h0000_007A; cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0; sleep_mode = 1'b1;
    @(negedge clk);
    check({pad_oe[6], pad_pu[6], pad_pd[6]} === 3'b110, "R8 sleep flags",
          64'({pad_oe[6], pad_pu[6], pad_pd[6]}), 64'h6);
    step();
    sleep_mode = 1'b0;
    @(negedge clk);
    check({pad_oe[6], pad_pu[6], pad_pd[6]} === 3'b001, "R8 normal flags restored",
          64'({pad_oe[6], pad_pu[6], pad_pd[6]}), 64'h1);

    // R9 illegal codes: index 7 serves pad 7
    for (int k = 0; k < 3; k++) begin
      logic [31:0] bad;
      bad = (k == 0) ? 32'h1011 : (k == 1) ? 32'h1021 : 32'h10B1;
      wr(8'h20, bad);
      step();
      fn_out = '1; fn_oe = '1; gpio_out = '1; gpio_dir = '1;
      @(negedge clk);
      check(pad_oe[7] === 1'b0 && pad_out[7] === 1'b0, "R9 illegal code undriven",
            64'({pad_out[7], pad_oe[7]}), 64'h0);
    end

    // mixed random traffic, judged by the model each clock
    for (int n = 0; n < 400; n++) begin
      step();
      cfg_wr     = ($urandom % 2) == 0;
      cfg_addr   = ($urandom % 4 == 0) ? 8'($urandom) : 8'((($urandom % 16) + 1) * 4);
      cfg_wdata  = $urandom;
      sleep_mode = $urandom % 2;
      gpio_out   = 16'($urandom);
      gpio_dir   = 16'($urandom);
      fn_out     = {16'($urandom), $urandom, $urandom};
      fn_oe      = {16'($urandom), $urandom, $urandom};
    end
    step();
    cfg_wr = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule